// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words for a two-channel frequency synthesizer over three slow inputs: a serial data line, a serial clock, and a load strobe. All three are brought into the system clock domain through two-flop synchronizers. Each detected rising edge of the serial clock shifts one data bit into a 23-bit shift register. Each detected rising edge of the load strobe copies the shift register into one of four holding registers.

The two bits sent last in a word select the destination. They also decide how the rest of the word is read. A word can set the reference divider of the low or high channel, or the main and swallow divider pair of the low or high channel. Shifting by itself never changes a holding register. The outputs are the held fields, wired straight to the divider counters. A reference word whose ratio is below the smallest legal value is dropped, and the old setting is kept.

Top module: `tri_wire_cfg`

## Requirements
- R1: After reset, every output field is zero.
- R2: Rising edges of the serial clock without a load-strobe rising edge leave every output unchanged.
- R3: A word is sent most significant bit first. The last bit shifted in lands in word bit 0, and only the last 23 bits shifted before the load take part. Earlier bits are discarded.
- R4: Word bit 0 is the band select (0 = low channel, 1 = high channel). Word bit 1 is the kind select (0 = reference word, 1 = main word). A load writes only the one holding register addressed by these two bits.
- R5: In a reference word, bits 3:2 are two test bits, bits 17:4 are the 14-bit reference ratio (bit 4 is its LSB), bit 18 is the charge-pump current select, and bits 22:19 are ignored.
- R6: In a main word, bits 8:2 are the 7-bit swallow count (bit 2 is its LSB), bits 19:9 are the 11-bit main count (bit 9 is its LSB), and bits 22:20 are ignored.
- R7: A reference word with a ratio of 0, 1 or 2 is rejected. The addressed reference register keeps its ratio, test bits and charge-pump bit. Ratios from 3 to 16383 are accepted.
- R8: The load takes effect only on a rising edge of the load strobe. Holding the strobe high while more bits are shifted does not update any register until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_load | input | 1 | Load strobe (asynchronous) |
| lo_ref_div | output | 14 | Low-channel reference ratio |
| lo_ref_test | output | 2 | Low-channel test bits |
| lo_ref_cp | output | 1 | Low-channel charge-pump select |
| hi_ref_div | output | 14 | High-channel reference ratio |
| hi_ref_test | output | 2 | High-channel test bits |
| hi_ref_cp | output | 1 | High-channel charge-pump select |
| lo_main_n | output | 11 | Low-channel main count |
| lo_main_a | output | 7 | Low-channel swallow count |
| hi_main_n | output | 11 | High-channel main count |
| hi_main_a | output | 7 | High-channel swallow count |

## Verification
The hardest case to reach from the ports is a load strobe that stays high while a new word is shifted underneath it. A correct design must ignore both the level and the new bits, and commit them only on the next strobe edge. The bench reaches this case by raising the strobe, clocking in a complete different word, and checking that nothing moved. It then lowers and raises the strobe and checks that the new word arrives. The bench also sweeps all four destinations over ratios from 0 upward, including the reject boundary at 3 and the maximum of 16383. It sends over-long words to show that only the trailing 23 bits count.

// File: rtl/tri_wire_cfg.sv
module tri_wire_cfg #(
  parameter int WORD_W  = 23,
  parameter int REF_W   = 14,
  parameter int N_W     = 11,
  parameter int A_W     = 7,
  parameter int MIN_REF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             ser_load,
  output logic [REF_W-1:0] lo_ref_div,
  output logic [1:0]       lo_ref_test,
  output logic             lo_ref_cp,
  output logic [REF_W-1:0] hi_ref_div,
  output logic [1:0]       hi_ref_test,
  output logic             hi_ref_cp,
  output logic [N_W-1:0]   lo_main_n,
  output logic [A_W-1:0]   lo_main_a,
  output logic [N_W-1:0]   hi_main_n,
  output logic [A_W-1:0]   hi_main_a
);
  localparam int REF_LSB = 4;
  localparam int CP_BIT  = REF_LSB + REF_W;
  localparam int A_LSB   = 2;
  localparam int N_LSB   = A_LSB + A_W;

  logic [2:0]        ck_q, ld_q;
  logic [1:0]        dq;
  logic [WORD_W-1:0] sr;
  logic              ck_rise, ld_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      ld_q <= '0;
      dq   <= '0;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      ld_q <= {ld_q[1:0], ser_load};
      dq   <= {dq[0], ser_data};
    end

  assign ck_rise = ck_q[1] & ~ck_q[2];
  assign ld_rise = ld_q[1] & ~ld_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sr <= '0;
    else if (ck_rise) sr <= {sr[WORD_W-2:0], dq[1]};

  logic             band, is_main, ref_ok;
  logic [REF_W-1:0] ref_val;
  logic             unused_bits;

  assign band        = sr[0];
  assign is_main     = sr[1];
  assign ref_val     = sr[REF_LSB +: REF_W];
  assign ref_ok      = ref_val >= REF_W'(MIN_REF);
  assign unused_bits = ^sr[WORD_W-1:N_LSB+N_W];

  logic [REF_W-1:0] ref_div [2];
  logic [1:0]       ref_tst [2];
  logic [1:0]       ref_cp;
  logic [N_W-1:0]   main_n  [2];
  logic [A_W-1:0]   main_a  [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_cp <= '0;
      for (int i = 0; i < 2; i++) begin
        ref_div[i] <= '0;
        ref_tst[i] <= '0;
        main_n[i]  <= '0;
        main_a[i]  <= '0;
      end
    end else if (ld_rise) begin
      if (is_main) begin
        main_n[band] <= sr[N_LSB +: N_W];
        main_a[band] <= sr[A_LSB +: A_W];
      end else if (ref_ok) begin
        ref_div[band] <= ref_val;
        ref_tst[band] <= sr[3:2];
        ref_cp[band]  <= sr[CP_BIT];
      end
    end

  assign lo_ref_div  = ref_div[0];
  assign hi_ref_div  = ref_div[1];
  assign lo_ref_test = ref_tst[0];
  assign hi_ref_test = ref_tst[1];
  assign lo_ref_cp   = ref_cp[0];
  assign hi_ref_cp   = ref_cp[1];
  assign lo_main_n   = main_n[0];
  assign hi_main_n   = main_n[1];
  assign lo_main_a   = main_a[0];
  assign hi_main_a   = main_a[1];
endmodule

// File: rtl/tri_wire_cfg_chk.sv
module tri_wire_cfg_chk #(
  parameter int WORD_W  = 23,
  parameter int REF_W   = 14,
  parameter int N_W     = 11,
  parameter int A_W     = 7,
  parameter int MIN_REF = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_rise,
  input logic [WORD_W-1:0] sr,
  input logic [REF_W-1:0] lo_ref_div,
  input logic [REF_W-1:0] hi_ref_div,
  input logic [N_W-1:0]   lo_main_n,
  input logic [A_W-1:0]   lo_main_a,
  input logic [N_W-1:0]   hi_main_n,
  input logic [A_W-1:0]   hi_main_a
);
  localparam int REF_LSB = 4;
  localparam int A_LSB   = 2;
  localparam int N_LSB   = A_LSB + A_W;

  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> ($stable(lo_ref_div) && $stable(hi_ref_div) && $stable(lo_main_n)
                 && $stable(hi_main_n) && $stable(lo_main_a) && $stable(hi_main_a)));

  a_r4_lo_ref_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && sr[1:0] == 2'b00 && sr[REF_LSB +: REF_W] >= REF_W'(MIN_REF))
    |=> (lo_ref_div == $past(sr[REF_LSB +: REF_W]) && $stable(hi_ref_div)));

  a_r6_hi_main_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && sr[1:0] == 2'b11)
    |=> (hi_main_n == $past(sr[N_LSB +: N_W]) && hi_main_a == $past(sr[A_LSB +: A_W])
         && $stable(lo_main_n)));

  a_r7_reject_low_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && !sr[1] && sr[REF_LSB +: REF_W] < REF_W'(MIN_REF))
    |=> ($stable(lo_ref_div) && $stable(hi_ref_div)));

  a_r7_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_ref_div == '0 || lo_ref_div >= REF_W'(MIN_REF)) &&
    (hi_ref_div == '0 || hi_ref_div >= REF_W'(MIN_REF)));
endmodule

bind tri_wire_cfg tri_wire_cfg_chk #(
  .WORD_W(WORD_W), .REF_W(REF_W), .N_W(N_W), .A_W(A_W), .MIN_REF(MIN_REF)
) u_chk (.*);

// File: tb/tri_wire_cfg_bench.sv
module tri_wire_cfg_bench;
  logic clk = 0, rst_n = 0, ser_data = 0, ser_clk = 0, ser_load = 0;
  logic [13:0] lo_ref_div, hi_ref_div;
  logic [1:0]  lo_ref_test, hi_ref_test;
  logic        lo_ref_cp, hi_ref_cp;
  logic [10:0] lo_main_n, hi_main_n;
  logic [6:0]  lo_main_a, hi_main_a;

  tri_wire_cfg u_tri_wire_cfg (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int e_rdiv [2], e_rtst [2], e_rcp [2], e_mn [2], e_ma [2];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " lo_ref_div"},  lo_ref_div,  e_rdiv[0]);
    chk({tag, " hi_ref_div"},  hi_ref_div,  e_rdiv[1]);
    chk({tag, " lo_ref_test"}, lo_ref_test, e_rtst[0]);
    chk({tag, " hi_ref_test"}, hi_ref_test, e_rtst[1]);
    chk({tag, " lo_ref_cp"},   lo_ref_cp,   e_rcp[0]);
    chk({tag, " hi_ref_cp"},   hi_ref_cp,   e_rcp[1]);
    chk({tag, " lo_main_n"},   lo_main_n,   e_mn[0]);
    chk({tag, " hi_main_n"},   hi_main_n,   e_mn[1]);
    chk({tag, " lo_main_a"},   lo_main_a,   e_ma[0]);
    chk({tag, " hi_main_a"},   hi_main_a,   e_ma[1]);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_data = w[i];
      tick(3);
      ser_clk = 1;
      tick(3);
      ser_clk = 0;
    end
    tick(3);
  endtask

  task automatic load_pulse();
    ser_load = 1;
    tick(4);
    ser_load = 0;
    tick(6);
  endtask

  function automatic logic [22:0] ref_word(input int band, input int r, input int t, input int cp, input int dc);
    return {dc[3:0], cp[0], r[13:0], t[1:0], 1'b0, band[0]};
  endfunction

  function automatic logic [22:0] main_word(input int band, input int n, input int a, input int dc);
    return {dc[2:0], n[10:0], a[6:0], 1'b1, band[0]};
  endfunction

  task automatic model_load(input logic [22:0] w);
    int b;
    b = w[0];
    if (w[1]) begin
      e_mn[b] = w[19:9];
      e_ma[b] = w[8:2];
    end else if (w[17:4] >= 3) begin
      e_rdiv[b] = w[17:4];
      e_rtst[b] = w[3:2];
      e_rcp[b]  = w[18];
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [22:0] w, w2;
    for (int b = 0; b < 2; b++) begin
      e_rdiv[b] = 0; e_rtst[b] = 0; e_rcp[b] = 0; e_mn[b] = 0; e_ma[b] = 0;
    end
    tick(4);
    rst_n = 1;
    tick(2);
    check_all("R1 reset");

    // R4 R5 R6 R7: sweep every destination over a range of values
    for (int addr = 0; addr < 4; addr++) begin
      for (int k = 0; k < 12; k++) begin
        int r, n, a;
        r = (k < 6) ? k : ((k == 11) ? 16383 : (k * 1373 + addr * 77) % 16384);
        n = (k * 191 + addr * 5 + 3) % 2048;
        a = (k * 37 + addr) % 128;
        if (addr < 2) w = ref_word(addr, r, k % 4, k % 2, k * 3);
        else          w = main_word(addr - 2, n, a, k);
        shift_bits({9'b0, w}, 23);
        load_pulse();
        model_load(w);
        check_all((addr < 2) ? "R4 R5 R7 ref sweep" : "R4 R6 main sweep");
      end
    end

    // R2: shifting with no load leaves outputs alone
    shift_bits({9'b0, ref_word(0, 999, 3, 1, 15)}, 23);
    check_all("R2 shift only");

    // R3: leading extra bits are discarded
    w = main_word(0, 1234 % 2048, 99, 5);
    shift_bits(32'h7F, 7);
    shift_bits({9'b0, w}, 23);
    load_pulse();
    model_load(w);
    check_all("R3 long word");

    // R7: boundary ratio 2 rejected then 3 accepted on high channel
    w = ref_word(1, 2, 1, 0, 0);
    shift_bits({9'b0, w}, 23);
    load_pulse();
    check_all("R7 ratio 2 rejected");
    w = ref_word(1, 3, 2, 1, 9);
    shift_bits({9'b0, w}, 23);
    load_pulse();
    model_load(w);
    check_all("R7 ratio 3 accepted");

    // R8: strobe held high while a new word shifts in
    w  = main_word(1, 77, 12, 0);
    shift_bits({9'b0, w}, 23);
    ser_load = 1;
    tick(6);
    model_load(w);
    check_all("R8 first edge");
    w2 = main_word(1, 555, 100, 7);
    shift_bits({9'b0, w2}, 23);
    check_all("R8 level held");
    ser_load = 0;
    tick(6);
    check_all("R8 after fall");
    load_pulse();
    model_load(w2);
    check_all("R8 second edge");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule